// File: doc/BRIEF.md
# Serial-Bus Configuration Register Bank Slave

This block is a two-wire serial bus slave (I2C) that lets a bus master read and write a small bank of 8-bit configuration registers. Both bus lines are sampled with the system clock, synchronised and filtered. The block recognises START, repeated START and STOP conditions, matches its 7-bit address, and acknowledges each byte it accepts. It drives the data line only through an active-high pull-low enable.

The first byte written after the address is a command byte. It holds a 3-bit register pointer and an auto-increment flag. Later bytes in the same transfer are written to the register the pointer selects. A read is a command-byte write followed by a repeated START with the read bit set. The slave then sends bytes for as long as the master acknowledges them. Register 0 reflects an external pin-state input. Registers 1 to 6 drive two rate/duty pairs and two pin-mode selector bytes at the block's outputs.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The slave answers only to the address whose upper four bits are 1100 and whose low three bits equal `addr_strap`; the eighth address bit is 1 for a read and 0 for a write. The slave acknowledges by asserting `sda_pull` through the ninth clock. On an address mismatch it does not acknowledge and ignores the bus until the next START or STOP.
- R2: The first byte written after a matching write address is the command byte. Its bits 2:0 are the register pointer and its bit 4 is the auto-increment flag. The command byte resets to 00h, so the pointer starts at 0 with auto-increment off.
- R3: A data byte written with pointer 1 to 6 updates, in pointer order, `rate_a`, `duty_a`, `rate_b`, `duty_b`, `mode_lo` and `mode_hi`, and each of these registers reads back its stored value.
- R4: After reset `rate_a` = FFh, `duty_a` = 80h, `rate_b` = 00h, `duty_b` = 80h, and `mode_lo` = `mode_hi` = 00h.
- R5: With auto-increment set, the pointer advances by one after every data byte that is read or written, and it moves from 6 back to 0.
- R6: With auto-increment clear, the pointer does not move, so repeated data bytes all access the same register.
- R7: Pointer 0 reads the `pin_state` input. A write to pointer 0 is acknowledged and changes no register.
- R8: Pointer 7 reads as 00h. A write to pointer 7 is acknowledged and changes no register.
- R9: In a read, bytes go out most significant bit first. The slave continues with the next byte after a master ACK. After a master NACK it leaves the data line released until the next START.
- R10: A pulse on SCL or SDA shorter than `FILT_CYC` system clocks has no effect on the transfer.
- R11: `sda_pull` changes only while the filtered SCL is low, and it is released in the cycle after a STOP.
- R12: While `rst_n` is low, all registers, the command byte and the bus state hold their reset values and `sda_pull` is low, even in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled serial clock line |
| sda_in | input | 1 | Sampled serial data line |
| sda_pull | output | 1 | 1 pulls the data line low |
| addr_strap | input | 3 | Low three address bits |
| pin_state | input | 8 | Pin levels returned by register 0 |
| rate_a | output | 8 | Register 1, rate of generator A |
| duty_a | output | 8 | Register 2, duty of generator A |
| rate_b | output | 8 | Register 3, rate of generator B |
| duty_b | output | 8 | Register 4, duty of generator B |
| mode_lo | output | 8 | Register 5, modes for pins 0 to 3 |
| mode_hi | output | 8 | Register 6, modes for pins 4 to 7 |

## Verification
Two functions can fall in the same cycle. The byte-completion pulse moves the pointer, and the decoder selects the write target from that same pointer. If the update were early, a byte could land in the next register. The bench provokes this with auto-increment bursts that start at pointer 5, which cross both the wrap from 6 to 0 and the discarded write to register 0. It judges the result from every output register and from a read-back burst. A second overlap is a glitch on SDA while SCL is high: the filter must absorb it, or the same cycle would produce a false START or STOP in the middle of a data byte.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
  localparam int BYTE_W   = 8;
  localparam int PTR_W    = 3;
  localparam int CFG_REGS = 6;
  localparam int CFG_W    = CFG_REGS * BYTE_W;
  localparam logic [3:0] ADDR_HI = 4'b1100;
  localparam int AI_BIT = 4;

  typedef enum logic [2:0] {
    BS_IDLE, BS_ADDR, BS_WRITE, BS_READ, BS_IGNORE
  } bus_state_e;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    ptr_step = (p >= PTR_W'(CFG_REGS)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [BYTE_W-1:0] cfg_reset(input int idx);
    case (idx)
      1:       cfg_reset = 8'hFF;
      2, 4:    cfg_reset = 8'h80;
      default: cfg_reset = 8'h00;
    endcase
  endfunction

  function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [2:0] strap);
    addr_hit = (b[7:4] == ADDR_HI) && (b[3:1] == strap);
  endfunction
endpackage

// File: rtl/i2c_rb_filter.sv
module i2c_rb_filter #(
  parameter int FILT_CYC = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_out
);
  localparam int CNT_W = $clog2(FILT_CYC + 1);
  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 2'b11;
      cnt_q    <= '0;
      line_out <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_in};
      if (sync_q[1] == line_out) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_W'(FILT_CYC - 1)) begin
        cnt_q    <= '0;
        line_out <= sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_rb_bus.sv
module i2c_rb_bus
  import i2c_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic [2:0]        addr_strap,
  input  logic [BYTE_W-1:0] rdata,
  output logic              sda_pull,
  output logic              cmd_wr,
  output logic              data_wr,
  output logic              rd_done,
  output logic [BYTE_W-1:0] wdata,
  output logic              start_evt,
  output logic              stop_evt
);
  bus_state_e        state_q;
  logic              scl_d, sda_d;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg, tx_q;
  logic              rw_q, cmd_next, mack_q;
  logic              scl_rise, scl_fall;

  assign scl_rise  = scl_f & ~scl_d;
  assign scl_fall  = ~scl_f & scl_d;
  assign start_evt = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_evt  = scl_f & scl_d & ~sda_d & sda_f;
  assign wdata     = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= BS_IDLE;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx_q     <= '0;
      rw_q     <= 1'b0;
      cmd_next <= 1'b0;
      mack_q   <= 1'b0;
      sda_pull <= 1'b0;
      cmd_wr   <= 1'b0;
      data_wr  <= 1'b0;
      rd_done  <= 1'b0;
    end else begin
      scl_d   <= scl_f;
      sda_d   <= sda_f;
      cmd_wr  <= 1'b0;
      data_wr <= 1'b0;
      rd_done <= 1'b0;
      if (start_evt) begin
        state_q  <= BS_ADDR;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
      end else if (stop_evt) begin
        state_q  <= BS_IDLE;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
      end else if (scl_rise) begin
        if ((state_q == BS_ADDR || state_q == BS_WRITE) && bit_cnt < 4'd8)
          shreg <= {shreg[BYTE_W-2:0], sda_f};
        if (state_q == BS_READ && bit_cnt == 4'd8)
          mack_q <= ~sda_f;
        if ((state_q == BS_ADDR || state_q == BS_WRITE || state_q == BS_READ) &&
            bit_cnt < 4'd9)
          bit_cnt <= bit_cnt + 1'b1;
      end else if (scl_fall) begin
        case (state_q)
          BS_ADDR: begin
            if (bit_cnt == 4'd8) begin
              if (addr_hit(shreg, addr_strap)) begin
                sda_pull <= 1'b1;
                rw_q     <= shreg[0];
              end else begin
                state_q <= BS_IGNORE;
              end
            end else if (bit_cnt == 4'd9) begin
              bit_cnt <= '0;
              if (rw_q) begin
                state_q  <= BS_READ;
                tx_q     <= rdata;
                sda_pull <= ~rdata[BYTE_W-1];
              end else begin
                state_q  <= BS_WRITE;
                cmd_next <= 1'b1;
                sda_pull <= 1'b0;
              end
            end
          end
          BS_WRITE: begin
            if (bit_cnt == 4'd8) begin
              sda_pull <= 1'b1;
              if (cmd_next) cmd_wr <= 1'b1;
              else          data_wr <= 1'b1;
            end else if (bit_cnt == 4'd9) begin
              sda_pull <= 1'b0;
              bit_cnt  <= '0;
              cmd_next <= 1'b0;
            end
          end
          BS_READ: begin
            if (bit_cnt >= 4'd1 && bit_cnt <= 4'd7) begin
              sda_pull <= ~tx_q[BYTE_W-2];
              tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
            end else if (bit_cnt == 4'd8) begin
              sda_pull <= 1'b0;
              rd_done  <= 1'b1;
            end else if (bit_cnt == 4'd9) begin
              if (mack_q) begin
                bit_cnt  <= '0;
                tx_q     <= rdata;
                sda_pull <= ~rdata[BYTE_W-1];
              end else begin
                state_q <= BS_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs
  import i2c_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              data_wr,
  input  logic              rd_done,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] pin_state,
  output logic [BYTE_W-1:0] rdata,
  output logic [PTR_W-1:0]  ptr,
  output logic              ai,
  output logic [CFG_W-1:0]  cfg_flat
);
  logic [BYTE_W-1:0] cmd_q;
  logic              byte_done;

  assign ptr       = cmd_q[PTR_W-1:0];
  assign ai        = cmd_q[AI_BIT];
  assign byte_done = data_wr | rd_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_wr) begin
      cmd_q <= wdata;
    end else if (byte_done && ai) begin
      cmd_q[PTR_W-1:0] <= ptr_step(ptr);
    end
  end

  for (genvar i = 1; i <= CFG_REGS; i++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_flat[(i-1)*BYTE_W +: BYTE_W] <= cfg_reset(i);
      else if (data_wr && ptr == PTR_W'(i))
        cfg_flat[(i-1)*BYTE_W +: BYTE_W] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (ptr == '0) rdata = pin_state;
    for (int k = 1; k <= CFG_REGS; k++)
      if (ptr == PTR_W'(k)) rdata = cfg_flat[(k-1)*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
  import i2c_rb_pkg::*;
#(
  parameter int FILT_CYC = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  input  logic [2:0] addr_strap,
  input  logic [7:0] pin_state,
  output logic [7:0] rate_a,
  output logic [7:0] duty_a,
  output logic [7:0] rate_b,
  output logic [7:0] duty_b,
  output logic [7:0] mode_lo,
  output logic [7:0] mode_hi
);
  logic              scl_f, sda_f;
  logic              cmd_wr, data_wr, rd_done, start_evt, stop_evt;
  logic [BYTE_W-1:0] wdata, rdata;
  logic [PTR_W-1:0]  ptr;
  logic              ai;
  logic [CFG_W-1:0]  cfg_flat;
  logic              data_done;

  assign data_done = data_wr | rd_done;

  i2c_rb_filter #(.FILT_CYC(FILT_CYC)) u_scl_filt (
    .clk(clk), .rst_n(rst_n), .line_in(scl_in), .line_out(scl_f));
  i2c_rb_filter #(.FILT_CYC(FILT_CYC)) u_sda_filt (
    .clk(clk), .rst_n(rst_n), .line_in(sda_in), .line_out(sda_f));

  i2c_rb_bus u_bus (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .addr_strap(addr_strap), .rdata(rdata), .sda_pull(sda_pull),
    .cmd_wr(cmd_wr), .data_wr(data_wr), .rd_done(rd_done), .wdata(wdata),
    .start_evt(start_evt), .stop_evt(stop_evt));

  i2c_rb_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr),
    .rd_done(rd_done), .wdata(wdata), .pin_state(pin_state), .rdata(rdata),
    .ptr(ptr), .ai(ai), .cfg_flat(cfg_flat));

  assign rate_a  = cfg_flat[0*BYTE_W +: BYTE_W];
  assign duty_a  = cfg_flat[1*BYTE_W +: BYTE_W];
  assign rate_b  = cfg_flat[2*BYTE_W +: BYTE_W];
  assign duty_b  = cfg_flat[3*BYTE_W +: BYTE_W];
  assign mode_lo = cfg_flat[4*BYTE_W +: BYTE_W];
  assign mode_hi = cfg_flat[5*BYTE_W +: BYTE_W];
endmodule

// File: rtl/i2c_regbank_checker.sv
module i2c_regbank_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_f,
  input logic        sda_pull,
  input logic        stop_evt,
  input logic        data_wr,
  input logic        data_done,
  input logic [2:0]  ptr,
  input logic        ai,
  input logic [47:0] cfg_flat
);
  // R11: the data line moves only while the filtered clock is low
  assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_f);
  // R11: a STOP releases the line
  assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull);
  // R7: writes to the pin-state register leave the bank untouched
  assert_ro_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ptr == 3'd0) |=> $stable(cfg_flat));
  // R8: writes to pointer 7 leave the bank untouched
  assert_ptr7_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ptr == 3'd7) |=> $stable(cfg_flat));
  // R5: pointer wraps from the last register to 0
  assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_done && ai && ptr == 3'd6) |=> (ptr == 3'd0));
  // R6: without auto-increment the pointer holds
  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_done && !ai) |=> $stable(ptr));
endmodule

bind i2c_regbank_slave i2c_regbank_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_pull(sda_pull),
  .stop_evt(stop_evt), .data_wr(data_wr), .data_done(data_done),
  .ptr(ptr), .ai(ai), .cfg_flat(cfg_flat));

// File: tb/i2c_regbank_slave_bench.sv
module i2c_regbank_slave_bench;
  localparam int Q = 16;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] AW = {4'b1100, STRAP, 1'b0};
  localparam logic [7:0] AR = {4'b1100, STRAP, 1'b1};

  typedef struct packed { logic [7:0] cmd; logic [7:0] data; } vec_t;
  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{8'h01, 8'h3C}, '{8'h02, 8'hA5}, '{8'h03, 8'h11}, '{8'h04, 8'h40},
    '{8'h05, 8'h5A}, '{8'h06, 8'hC3}, '{8'h00, 8'h77}, '{8'h07, 8'h99}};

  logic clk = 0, rst_n = 0;
  logic m_scl = 1, m_sda = 1;
  logic sda_pull;
  logic [7:0] pin_state = 8'h5A;
  logic [7:0] rate_a, duty_a, rate_b, duty_b, mode_lo, mode_hi;
  logic sda_bus;
  int checks = 0, errors = 0;
  logic [7:0] model [1:6];
  logic [7:0] rbuf [8];
  logic [7:0] wbuf [8];
  logic ackv;
  logic [7:0] rb;

  always #4 clk = ~clk;
  assign sda_bus = m_sda & ~sda_pull;

  i2c_regbank_slave u_i2c_regbank_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .sda_pull(sda_pull), .addr_strap(STRAP), .pin_state(pin_state),
    .rate_a(rate_a), .duty_a(duty_a), .rate_b(rate_b), .duty_b(duty_b),
    .mode_lo(mode_lo), .mode_hi(mode_hi));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start;
    m_sda = 1; wq(Q); m_scl = 1; wq(Q); m_sda = 0; wq(Q); m_scl = 0; wq(Q);
  endtask

  task automatic m_stop;
    m_sda = 0; wq(Q); m_scl = 1; wq(Q); m_sda = 1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic glitch, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      if (glitch && i == 4) begin
        m_scl = 1; wq(3); m_scl = 0;
      end
      wq(Q); m_sda = b[i]; wq(Q); m_scl = 1; wq(Q);
      if (glitch && i == 2) begin
        m_sda = ~b[i]; wq(3); m_sda = b[i];
      end
      wq(Q); m_scl = 0;
    end
    wq(Q); m_sda = 1; wq(Q); m_scl = 1; wq(Q);
    acked = ~sda_bus;
    wq(Q); m_scl = 0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      wq(2*Q); m_scl = 1; wq(Q); b[i] = sda_bus; wq(Q); m_scl = 0;
    end
    wq(Q); m_sda = ~give_ack; wq(Q); m_scl = 1; wq(2*Q); m_scl = 0;
  endtask

  task automatic wr_seq(input string req, input logic [7:0] cmd, input int n);
    m_start;
    send_byte(AW, 1'b0, ackv); chk("R1 address ack", {7'd0, ackv}, 8'd1);
    send_byte(cmd, 1'b0, ackv); chk({req, " cmd ack"}, {7'd0, ackv}, 8'd1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], 1'b0, ackv);
      chk({req, " data ack"}, {7'd0, ackv}, 8'd1);
    end
    m_stop;
  endtask

  task automatic rd_seq(input logic [7:0] cmd, input int n);
    m_start;
    send_byte(AW, 1'b0, ackv);
    send_byte(cmd, 1'b0, ackv);
    m_start;
    send_byte(AR, 1'b0, ackv); chk("R9 read address ack", {7'd0, ackv}, 8'd1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    wq(Q);
    chk("R9 line released after NACK", {7'd0, sda_pull}, 8'd0);
    m_stop;
  endtask

  function automatic logic [7:0] exp_rd(input logic [2:0] p);
    if (p == 3'd0) return pin_state;
    if (p == 3'd7) return 8'h00;
    return model[p];
  endfunction

  task automatic chk_outs(input string req);
    chk({req, " rate_a"}, rate_a, model[1]);
    chk({req, " duty_a"}, duty_a, model[2]);
    chk({req, " rate_b"}, rate_b, model[3]);
    chk({req, " duty_b"}, duty_b, model[4]);
    chk({req, " mode_lo"}, mode_lo, model[5]);
    chk({req, " mode_hi"}, mode_hi, model[6]);
  endtask

  task automatic model_reset;
    model[1] = 8'hFF; model[2] = 8'h80; model[3] = 8'h00;
    model[4] = 8'h80; model[5] = 8'h00; model[6] = 8'h00;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    wq(5);
    chk("R12 pull low in reset", {7'd0, sda_pull}, 8'd0);
    rst_n = 1; wq(5);
    chk_outs("R4 reset value");

    // R2: command byte resets to 00h, so a bare read returns register 0
    m_start;
    send_byte(AR, 1'b0, ackv); chk("R1 read address ack", {7'd0, ackv}, 8'd1);
    recv_byte(1'b0, rb); chk("R2 reset pointer reads pin_state", rb, 8'h5A);
    m_stop;

    // vector table: single write then read back (R3, R7, R8)
    for (int v = 0; v < NV; v++) begin
      wbuf[0] = VEC[v].data;
      wr_seq("R3", VEC[v].cmd, 1);
      if (VEC[v].cmd[2:0] >= 3'd1 && VEC[v].cmd[2:0] <= 3'd6)
        model[VEC[v].cmd[2:0]] = VEC[v].data;
      chk_outs(VEC[v].cmd[2:0] == 3'd0 ? "R7 write discarded" :
               VEC[v].cmd[2:0] == 3'd7 ? "R8 write discarded" : "R3 write");
      rd_seq(VEC[v].cmd, 1);
      chk(VEC[v].cmd[2:0] == 3'd0 ? "R7 read pin_state" :
          VEC[v].cmd[2:0] == 3'd7 ? "R8 read zero" : "R3 read back",
          rbuf[0], exp_rd(VEC[v].cmd[2:0]));
    end

    // R5: auto-increment burst from 5 crosses 6->0 (discarded) -> 1
    wbuf[0] = 8'h21; wbuf[1] = 8'h22; wbuf[2] = 8'h23; wbuf[3] = 8'h24;
    wr_seq("R5", 8'h15, 4);
    model[5] = 8'h21; model[6] = 8'h22; model[1] = 8'h24;
    chk_outs("R5 burst wrap");

    // R5/R9: read burst from 4 with auto-increment
    pin_state = 8'hE1;
    rd_seq(8'h14, 5);
    for (int i = 0; i < 5; i++)
      chk("R5 R9 read burst", rbuf[i], exp_rd(3'((4 + i) % 7)));

    // R6: no auto-increment, repeated bytes hit one register
    wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03;
    wr_seq("R6", 8'h02, 3);
    model[2] = 8'h03;
    chk_outs("R6 fixed pointer");
    rd_seq(8'h03, 3);
    for (int i = 0; i < 3; i++) chk("R6 read same register", rbuf[i], model[3]);

    // R1: address mismatch, no ack, bus ignored
    m_start;
    send_byte(AW ^ 8'h04, 1'b0, ackv); chk("R1 mismatch no ack", {7'd0, ackv}, 8'd0);
    send_byte(8'h01, 1'b0, ackv); chk("R1 ignored byte no ack", {7'd0, ackv}, 8'd0);
    send_byte(8'h66, 1'b0, ackv);
    m_stop;
    chk_outs("R1 mismatch leaves bank");

    // R10: short glitches on both lines inside a data byte
    m_start;
    send_byte(AW, 1'b0, ackv);
    send_byte(8'h04, 1'b0, ackv);
    send_byte(8'hB6, 1'b1, ackv); chk("R10 ack through glitches", {7'd0, ackv}, 8'd1);
    m_stop;
    model[4] = 8'hB6;
    chk_outs("R10 glitch rejected");
    chk("R11 released after stop", {7'd0, sda_pull}, 8'd0);

    // R12: reset during a transfer
    m_start;
    send_byte(AW, 1'b0, ackv);
    rst_n = 0; wq(4);
    model_reset();
    chk("R12 pull low during reset", {7'd0, sda_pull}, 8'd0);
    chk_outs("R12 mid-transfer reset");
    rst_n = 1; wq(4);
    m_stop;
    rd_seq(8'h11, 1);
    chk("R12 bank usable after reset", rbuf[0], 8'hFF);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule